// File: doc/BRIEF.md
# Dual-Source Reset and Processor Enable Controller

This block decides when the rest of the chip is held in reset and when the attached local processor and the two coprocessors (segmentation and reassembly) may run. A reset comes from either of two places: an active-low hardware pin, or a software-controlled global-reset bit in a 32-bit configuration word. The pin is brought into the clock domain by a two-stage synchroniser. It asserts asynchronously and releases synchronously. While the pin reset is in force, it clears the whole configuration word.

The local processor's reset output is released only when software sets the processor-enable bit. The two coprocessor enables are held off during any reset. They can be turned on only by a write made after the global-reset bit is already clear. A software global reset leaves the rest of the configuration word as it was. Software must set or clear those bits itself.

The configuration word is reached through a simple write strobe, an address and data, plus a combinational read-back on the same address.

Top module: `rst_enable_ctl`

## Requirements
- R1: While `rst_pin_n` is low, `chip_rst` and `rst_active` are 1 at once without waiting for a clock, `lp_rst_n`, `seg_en` and `rsm_en` are 0, and the configuration word reads back as 0.
- R2: After `rst_pin_n` rises between clock edges, `chip_rst` stays 1 after the first following rising edge and falls to 0 after the second (when bit 30 of the configuration word is 0).
- R3: Writes made while the pin reset is in force, including the two synchroniser cycles after release, are ignored and the word stays 0.
- R4: A write with `reg_addr` equal to 0x14 stores `reg_wdata` at the next rising edge. Two exceptions apply: bits 0 and 1, which follow R6, and any write while R3 applies. Reads at 0x14 return the stored word. Reads at any other address return 0, and writes at any other address change nothing.
- R5: Bit 30 of the configuration word is the global reset. While it is 1, `chip_rst` and `rst_active` are 1, and clearing it by a write drops them after that write's edge.
- R6: Bit 0 enables segmentation and bit 1 enables reassembly. A write stores them as 0 whenever bit 30 is 1 either before the write or in the written data. So enabling a coprocessor takes a write made after bit 30 is clear.
- R7: `lp_rst_n` equals bit 31 of the configuration word whenever the pin reset is not in force. It can rise only after a write that sets bit 31, and setting or clearing bit 30 leaves it unchanged.
- R8: With no reset active, `seg_en` follows bit 0 and `rsm_en` follows bit 1. Both are 0 whenever `chip_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Active-low hardware reset pin, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| chip_rst | output | 1 | Internal chip reset, active high |
| rst_active | output | 1 | Status: an internal reset is in force |
| lp_rst_n | output | 1 | Local processor reset, active low |
| seg_en | output | 1 | Segmentation coprocessor enable |
| rsm_en | output | 1 | Reassembly coprocessor enable |

## Verification
The bench times the pin release edge by edge. A synchroniser that is one stage short or long would drop `chip_rst` a cycle early or late. It also writes during the release window, and a design that accepted those writes would read back non-zero. The bench writes data that sets bit 30 and the coprocessor bits together, then data that clears bit 30 and sets those bits in the same write. A design that let either write through would raise an enable while a reset is pending. Random writes at mixed addresses, some with bit 31, are compared against a bench model. That comparison catches a processor reset that is tied to the global reset, and a word that is overwritten by writes to other addresses.

// File: rtl/rst_enable_ctl.sv
module rst_enable_ctl #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int CFG_ADDR  = 'h14,
  parameter int LPEN_BIT  = 31,
  parameter int GRST_BIT  = 30,
  parameter int SEG_BIT   = 0,
  parameter int RSM_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              chip_rst,
  output logic              rst_active,
  output logic              lp_rst_n,
  output logic              seg_en,
  output logic              rsm_en
);

  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

  logic [1:0]        sync_q;
  logic              pin_rst;
  logic [DATA_W-1:0] cfg_q;
  logic [DATA_W-1:0] cfg_nxt;
  logic              cfg_hit;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) sync_q <= 2'b00;
    else            sync_q <= {sync_q[0], 1'b1};

  assign pin_rst = ~sync_q[1];
  assign cfg_hit = reg_wr && (reg_addr == CFG_A);

  always_comb begin
    cfg_nxt = reg_wdata;
    if (cfg_q[GRST_BIT] || reg_wdata[GRST_BIT]) begin
      cfg_nxt[SEG_BIT] = 1'b0;
      cfg_nxt[RSM_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n)   cfg_q <= '0;
    else if (pin_rst) cfg_q <= '0;
    else if (cfg_hit) cfg_q <= cfg_nxt;

  assign chip_rst   = pin_rst | cfg_q[GRST_BIT];
  assign rst_active = chip_rst;
  assign lp_rst_n   = cfg_q[LPEN_BIT] & ~pin_rst;
  assign seg_en     = cfg_q[SEG_BIT] & ~chip_rst;
  assign rsm_en     = cfg_q[RSM_BIT] & ~chip_rst;
  assign reg_rdata  = (reg_addr == CFG_A) ? cfg_q : '0;

  // R3
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !sync_q[1] |=> (cfg_q == '0));

  // R5
  grst_enter_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (cfg_hit && !pin_rst && reg_wdata[GRST_BIT]) |=> chip_rst);

  // R8
  coproc_off_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    chip_rst |-> (!seg_en && !rsm_en));

  // R7
  lp_release_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(lp_rst_n) |-> $past(cfg_hit && reg_wdata[LPEN_BIT]));

endmodule

// File: tb/rst_enable_ctl_bench.sv
module rst_enable_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_pin_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        chip_rst, rst_active, lp_rst_n, seg_en, rsm_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] model;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  rst_enable_ctl u_rst_enable_ctl (
    .clk(clk), .rst_pin_n(rst_pin_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chip_rst(chip_rst),
    .rst_active(rst_active), .lp_rst_n(lp_rst_n), .seg_en(seg_en), .rsm_en(rsm_en)
  );

  function automatic logic [31:0] next_cfg(logic [31:0] cur, logic [31:0] wd);
    logic [31:0] v = wd;
    if (cur[30] || wd[30]) v[1:0] = 2'b00;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_model(string tag);
    reg_addr = 8'h14;
    #1;
    chk({tag, " rdata R4"}, reg_rdata, model);
    chk({tag, " chip_rst R5"}, {31'd0, chip_rst}, {31'd0, model[30]});
    chk({tag, " rst_active R5"}, {31'd0, rst_active}, {31'd0, model[30]});
    chk({tag, " lp_rst_n R7"}, {31'd0, lp_rst_n}, {31'd0, model[31]});
    chk({tag, " seg_en R8"}, {31'd0, seg_en}, {31'd0, model[0] & ~model[30]});
    chk({tag, " rsm_en R8"}, {31'd0, rsm_en}, {31'd0, model[1] & ~model[30]});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 8'h14) model = next_cfg(model, d);
  endtask

  task automatic pin_reset();
    @(negedge clk);
    rst_pin_n = 1'b0;
    #1;
    model = '0;
    chk("pin low chip_rst R1", {31'd0, chip_rst}, 32'd1);
    chk("pin low lp_rst_n R1", {31'd0, lp_rst_n}, 32'd0);
    reg_addr = 8'h14; #1;
    chk("pin low rdata R1", reg_rdata, 32'd0);
    @(negedge clk); #2;
    rst_pin_n = 1'b1;
    reg_wr = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h8000_0003;
    @(negedge clk);
    chk("release edge1 chip_rst R2", {31'd0, chip_rst}, 32'd1);
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    chk("release edge2 chip_rst R2", {31'd0, chip_rst}, 32'd0);
    chk("write during sync ignored R3", reg_rdata, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_pin_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h14; reg_wdata = '0;
    model = '0;
    #1;
    chk("time0 chip_rst R1", {31'd0, chip_rst}, 32'd1);
    chk("time0 seg_en R1", {31'd0, seg_en}, 32'd0);
    repeat (3) @(negedge clk);
    pin_reset();
    wr(8'h14, 32'h4000_0003);
    check_model("grst with enables R6");
    wr(8'h14, 32'h0000_0003);
    check_model("clear grst same write R6");
    wr(8'h14, 32'h0000_0003);
    check_model("enable after clear R8");
    wr(8'h14, 32'h8000_0003);
    check_model("lp enable R7");
    wr(8'h14, 32'hC000_0000);
    check_model("grst keeps lp R7");
    wr(8'h20, 32'h1234_5678);
    reg_addr = 8'h20; #1;
    chk("other address read R4", reg_rdata, 32'd0);
    check_model("other address write R4");
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = ($urandom % 3 == 0) ? 8'($urandom) : 8'h14;
      d = $urandom;
      if ($urandom % 2 == 0) d[30] = 1'b0;
      wr(a, d);
      check_model("random R4");
      if (i == 150) pin_reset();
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule